// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block management instruction (block zero, clean, flush or invalidate) may run or must trap. It holds the cache-block enable fields of three environment configuration levels: machine, hypervisor and supervisor. A configuration write port updates them. For each instruction presented on the check strobe, the block looks at the current privilege mode, the virtualization bit and the operation type. One clock later it reports one of three outcomes: allow, illegal-instruction trap or virtual-instruction trap.

The write port carries only the four enable bits of a configuration word, bits 7:4. The surrounding register file keeps the other bits of that word. Checks come one per cycle at most and need no back-pressure. The result is a plain registered strobe with a code, and the consumer must take it in the cycle it appears. The block never stalls the check input.

Top module: `cbo_perm_check`

## Requirements
- R1: `res_valid` is high in the clock cycle right after a cycle with `chk_valid` high, and low otherwise. `res_code` is 0 whenever `res_valid` is low.
- R2: Result codes are 0 for allow, 1 for illegal instruction and 2 for virtual instruction. Code 3 never appears. `chk_op` encodes 0 zero, 1 clean, 2 flush, 3 invalidate. `chk_priv` encodes 0 user, 1 supervisor, 3 machine.
- R3: Machine mode (`chk_priv`=3) is always allowed, whatever the enables are.
- R4: The reserved privilege encoding 2 always gives illegal instruction.
- R5: In user or supervisor mode, virtualized or not, a clear machine-level enable for the operation gives illegal instruction. This takes priority over every virtual-instruction condition.
- R6: When not virtualized, user mode with the supervisor-level enable clear gives illegal instruction. Supervisor mode needs only the machine-level enable.
- R7: When virtualized in supervisor mode, with the machine-level enable set and the hypervisor-level enable clear, the result is virtual instruction.
- R8: When virtualized in user mode, with the machine-level enable set and either the hypervisor-level or the supervisor-level enable clear, the result is virtual instruction.
- R9: The field layout is the same at every level. `cfg_field[3]` (word bit 7) enables zero. `cfg_field[2]` (word bit 6) enables both clean and flush. `cfg_field[1:0]` (word bits 5:4) enables invalidate when nonzero. `cfg_sel` selects 0 machine, 1 hypervisor, 2 supervisor. A write with `cfg_sel`=3 changes nothing.
- R10: Reset clears every enable. A write in the same cycle as a check affects only later checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Level select: 0 machine, 1 hypervisor, 2 supervisor |
| cfg_field | input | 4 | Enable bits 7:4 of the configuration word |
| chk_valid | input | 1 | Instruction check strobe |
| chk_priv | input | 2 | Current privilege mode |
| chk_virt | input | 1 | Virtualization bit |
| chk_op | input | 2 | Cache-block operation type |
| res_valid | output | 1 | Result strobe, one cycle after `chk_valid` |
| res_code | output | 2 | Outcome: 0 allow, 1 illegal, 2 virtual |

## Verification
The bench sweeps eight settings of every level's enables, covering each invalidate bit and every privilege, virtualization and operation combination. This catches a design that lets a virtual trap win over a clear machine enable, or one that gives virtualized user mode only the hypervisor check. It also catches invalidate decoded from a single bit, and clean and flush decoded from different bits. Directed cases cover a write in the same cycle as a check, which a bypassing design would allow too early. They also cover a write to level select 3, which a design that wraps the select would apply to a real level, and the reserved privilege encoding, which a two-way mode decoder would let through.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;

  localparam int unsigned LVL_N   = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned LVL_M   = 0;
  localparam int unsigned LVL_H   = 1;
  localparam int unsigned LVL_S   = 2;

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } prv_e;

  typedef enum logic [1:0] {
    OP_ZERO  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } cbop_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_ILL  = 2'd1,
    RES_VIRT = 2'd2
  } res_e;

  // Enable bits 7:4 of a configuration word, MSB first
  typedef struct packed {
    logic       zero_en;
    logic       cf_en;
    logic [1:0] inv_en;
  } blkcfg_t;

  localparam int unsigned FIELD_W = $bits(blkcfg_t);

endpackage

// File: rtl/cbo_cfg_bank.sv
module cbo_cfg_bank
  import cbo_perm_pkg::*;
#(
  parameter int unsigned LEVELS = LVL_N
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [SEL_W-1:0]            sel,
  input  blkcfg_t                     wfield,
  output blkcfg_t [LEVELS-1:0]        cfg_q
);

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (we && (sel == SEL_W'(g))) begin
        cfg_q[g] <= wfield;
      end
    end
  end

endmodule

// File: rtl/cbo_op_gate.sv
module cbo_op_gate
  import cbo_perm_pkg::*;
(
  input  blkcfg_t cfg,
  input  cbop_e   op,
  output logic    en
);

  always_comb begin
    unique case (op)
      OP_ZERO:  en = cfg.zero_en;
      OP_CLEAN,
      OP_FLUSH: en = cfg.cf_en;
      OP_INVAL: en = |cfg.inv_en;
      default:  en = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbo_perm_decide.sv
module cbo_perm_decide
  import cbo_perm_pkg::*;
(
  input  logic en_m,
  input  logic en_h,
  input  logic en_s,
  input  prv_e prv,
  input  logic virt,
  output res_e res
);

  always_comb begin
    res = RES_OK;
    unique case (prv)
      PRV_M:   res = RES_OK;
      PRV_RSV: res = RES_ILL;
      default: begin
        if (!en_m) begin
          res = RES_ILL;
        end else if (!virt) begin
          res = (prv == PRV_U && !en_s) ? RES_ILL : RES_OK;
        end else if (prv == PRV_S) begin
          res = en_h ? RES_OK : RES_VIRT;
        end else begin
          res = (en_h && en_s) ? RES_OK : RES_VIRT;
        end
      end
    endcase
  end

endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
  import cbo_perm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [3:0]       cfg_field,
  input  logic             chk_valid,
  input  logic [1:0]       chk_priv,
  input  logic             chk_virt,
  input  logic [1:0]       chk_op,
  output logic             res_valid,
  output logic [1:0]       res_code
);

  blkcfg_t [LVL_N-1:0] cfg_q;
  logic    [LVL_N-1:0] lvl_en;
  res_e                dec_res;

  cbo_cfg_bank #(.LEVELS(LVL_N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wfield (blkcfg_t'(cfg_field)),
    .cfg_q  (cfg_q)
  );

  for (genvar g = 0; g < LVL_N; g++) begin : g_gate
    cbo_op_gate u_gate (
      .cfg (cfg_q[g]),
      .op  (cbop_e'(chk_op)),
      .en  (lvl_en[g])
    );
  end

  cbo_perm_decide u_decide (
    .en_m (lvl_en[LVL_M]),
    .en_h (lvl_en[LVL_H]),
    .en_s (lvl_en[LVL_S]),
    .prv  (prv_e'(chk_priv)),
    .virt (chk_virt),
    .res  (dec_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= RES_OK;
    end else begin
      res_valid <= chk_valid;
      res_code  <= chk_valid ? dec_res : RES_OK;
    end
  end

endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       chk_valid,
  input logic [1:0] chk_priv,
  input logic       chk_virt,
  input logic       en_m,
  input logic       res_valid,
  input logic [1:0] res_code
);

  // R1
  res_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);

  // R1
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> (!res_valid && res_code == 2'd0));

  // R2
  no_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_code != 2'd3);

  // R3
  mmode_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_priv == 2'd3) |=> res_code == 2'd0);

  // R4
  rsv_priv_ill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_priv == 2'd2) |=> res_code == 2'd1);

  // R5
  m_enable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_priv[1] && !en_m) |=> res_code == 2'd1);

  // R6
  nonvirt_no_vtrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_virt) |=> res_code != 2'd2);

endmodule

bind cbo_perm_check cbo_perm_check_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .chk_valid (chk_valid),
  .chk_priv  (chk_priv),
  .chk_virt  (chk_virt),
  .en_m      (lvl_en[0]),
  .res_valid (res_valid),
  .res_code  (res_code)
);

// File: tb/cbo_perm_check_bench.sv
`timescale 1ns/1ps
module cbo_perm_check_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [3:0] cfg_field = '0;
  logic       chk_valid = 1'b0;
  logic [1:0] chk_priv = '0;
  logic       chk_virt = 1'b0;
  logic [1:0] chk_op = '0;
  logic       res_valid;
  logic [1:0] res_code;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cbo_perm_check u_cbo_perm_check (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .chk_valid(chk_valid), .chk_priv(chk_priv),
    .chk_virt(chk_virt), .chk_op(chk_op), .res_valid(res_valid),
    .res_code(res_code)
  );

  function automatic logic op_en(logic [3:0] f, logic [1:0] op);
    if (op == 2'd0) return f[3];
    if (op == 2'd3) return |f[1:0];
    return f[2];
  endfunction

  function automatic logic [1:0] model(logic [3:0] m, logic [3:0] h, logic [3:0] s,
                                       logic [1:0] p, logic v, logic [1:0] op);
    logic em, eh, es;
    em = op_en(m, op); eh = op_en(h, op); es = op_en(s, op);
    if (p == 2'd3) return 2'd0;
    if (p == 2'd2) return 2'd1;
    if (!em) return 2'd1;
    if (!v) return (p == 2'd0 && !es) ? 2'd1 : 2'd0;
    if (p == 2'd1) return eh ? 2'd0 : 2'd2;
    return (eh && es) ? 2'd0 : 2'd2;
  endfunction

  task automatic expect_res(logic ev, logic [1:0] ec, string tag);
    n_chk++;
    if (res_valid !== ev || res_code !== ec) begin
      n_err++;
      $display("FAIL %s: got valid=%0b code=%0d, expected valid=%0b code=%0d",
               tag, res_valid, res_code, ev, ec);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [3:0] f);
    cfg_we = 1'b1; cfg_sel = sel; cfg_field = f;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(logic [1:0] p, logic v, logic [1:0] op, logic [1:0] ec, string tag);
    chk_valid = 1'b1; chk_priv = p; chk_virt = v; chk_op = op;
    @(negedge clk);
    chk_valid = 1'b0;
    expect_res(1'b1, ec, tag);
  endtask

  function automatic logic [3:0] nib(int n, logic [1:0] inv);
    return {n[2] ? 1'b1 : 1'b0, n[1] ? 1'b1 : 1'b0, n[0] ? inv : 2'b00};
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state, R1 idle outputs
    expect_res(1'b0, 2'd0, "R1/R10 reset outputs");
    // R10 enables cleared by reset
    chk(2'd1, 1'b0, 2'd0, 2'd1, "R10 reset clears enables");
    chk(2'd3, 1'b0, 2'd3, 2'd0, "R3 machine allowed after reset");
    @(negedge clk);
    expect_res(1'b0, 2'd0, "R1 idle cycle");

    // Sweep: R2 R3 R4 R5 R6 R7 R8 R9
    for (int mi = 0; mi < 8; mi++) begin
      for (int hi = 0; hi < 8; hi++) begin
        for (int si = 0; si < 8; si++) begin
          logic [3:0] fm, fh, fs;
          fm = nib(mi, 2'b01); fh = nib(hi, 2'b10); fs = nib(si, 2'b11);
          wr(2'd0, fm); wr(2'd1, fh); wr(2'd2, fs);
          for (int p = 0; p < 4; p++)
            for (int v = 0; v < 2; v++)
              for (int op = 0; op < 4; op++)
                chk(p[1:0], v[0], op[1:0], model(fm, fh, fs, p[1:0], v[0], op[1:0]),
                    "R2-sweep R3 R4 R5 R6 R7 R8 R9");
        end
      end
    end

    // R10 write in the same cycle as a check
    wr(2'd0, 4'h0); wr(2'd1, 4'hF); wr(2'd2, 4'hF);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_field = 4'hF;
    chk_valid = 1'b1; chk_priv = 2'd0; chk_virt = 1'b1; chk_op = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; chk_valid = 1'b0;
    expect_res(1'b1, 2'd1, "R10 same-cycle write not yet visible");
    chk(2'd0, 1'b1, 2'd0, 2'd0, "R10 write visible to later check");

    // R9 select 3 writes nothing
    wr(2'd3, 4'h0);
    chk(2'd0, 1'b1, 2'd3, 2'd0, "R9 select 3 ignored (inval)");
    chk(2'd0, 1'b0, 2'd1, 2'd0, "R9 select 3 ignored (clean)");
    // R9 each invalidate bit alone
    wr(2'd2, 4'b0001);
    chk(2'd0, 1'b0, 2'd3, 2'd0, "R9 inval low bit");
    wr(2'd2, 4'b0010);
    chk(2'd0, 1'b0, 2'd3, 2'd0, "R9 inval high bit");
    wr(2'd2, 4'b1100);
    chk(2'd0, 1'b0, 2'd3, 2'd1, "R9 inval zero field");
    chk(2'd0, 1'b0, 2'd2, 2'd0, "R9 flush shares clean enable");
    @(negedge clk);
    expect_res(1'b0, 2'd0, "R1 idle after checks");
    finish_up();
  end

endmodule